// File: doc/BRIEF.md
# Selectable Antiblooming Pulse Generator

This block drives the antiblooming gate of a frame-transfer CCD sensor. It runs from a master clock of about 13.375 MHz. A 3-bit mode input chooses one of five behaviours:

- no pulses at all;
- a 2 MHz or 1 MHz pulse train that appears only inside a burst window given by line timing;
- a 1 MHz or 2 MHz train that runs all the time.

Both rates come from one phase accumulator, which divides the master clock by a fraction. The pulse is high while the accumulator phase is in the lower half of its range.

Some mode codes share a behaviour. The block acts on the decoded behaviour and not on the raw code, so toggling a don't-care bit changes nothing. When the decoded behaviour changes, the output is forced low for one cycle and the phase restarts from zero. The next pulse is therefore always a full one.

A flag tells the surrounding timing logic that a pulsing mode is in effect. The 2 MHz burst is the setting used in normal operation.

Top module: `ab_pulse_gen`

## Requirements
- R1: Mode codes with bits [1:0] = 00 (bit 2 ignored) keep `ab_pulse` low at all times, and `mode_ok` reads 0.
- R2: Codes with bit 1 high and bit 0 low (bit 2 ignored) select a 2 MHz burst. Changing only bit 2 within this pair neither restarts nor disturbs the train.
- R3: Codes with bit 0 high and bit 1 low (bit 2 ignored) select a 1 MHz burst.
- R4: Code 111 selects a continuous 1 MHz train: 10 rising edges of `ab_pulse` in the 134 cycles after a mode change.
- R5: Code 011 selects a continuous 2 MHz train: 20 rising edges of `ab_pulse` in the 134 cycles after a mode change.
- R6: The phase is a 16-bit accumulator that advances by 9800 per cycle at 2 MHz and by 4900 per cycle at 1 MHz. Counting the mode-change edge as k = 0, the value of `ab_pulse` after clock edge k ≥ 1 is 1 exactly when ((k−1)·step mod 65536) < 32768, subject to R1 and R7.
- R7: In a burst mode, a clock edge that samples `burst_win` low makes `ab_pulse` low after that edge. The continuous modes ignore `burst_win`.
- R8: At the clock edge that first samples a different decoded behaviour, `ab_pulse` goes low and the phase returns to zero. Pulsing resumes on the following edge as a full-width pulse.
- R9: Synchronous active-high `rst` drives `ab_pulse` and `mode_ok` low, clears the phase, and selects the no-pulse behaviour internally.
- R10: `mode_ok` is 1 from the edge that accepts a pulsing mode, and stays 1 while that behaviour is in effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, about 13.375 MHz |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Behaviour select code |
| burst_win | input | 1 | High while burst pulses are allowed |
| ab_pulse | output | 1 | Antiblooming gate pulse |
| mode_ok | output | 1 | High while a pulsing behaviour is in effect |

## Verification
A phase that is wrong shows up at `ab_pulse` within one period, about seven cycles at 2 MHz. The high and low runs shift against the closed-form pattern of R6, and the edge count over 134 cycles comes out wrong. A decoder that misreads a don't-care bit causes a spurious restart, visible as a forced low cycle in the middle of the train. A missing restart leaves a runt or misaligned pulse on the edge right after a mode change. A gate fault appears on the first edge that samples the window low.

// File: rtl/ab_pulse_gen.sv
module ab_pulse_gen #(
  parameter int CLK_KHZ  = 13375,
  parameter int FAST_KHZ = 2000,
  parameter int SLOW_KHZ = 1000,
  parameter int ACC_W    = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] mode,
  input  logic       burst_win,
  output logic       ab_pulse,
  output logic       mode_ok
);

  localparam longint FULL = longint'(1) << ACC_W;
  localparam logic [ACC_W-1:0] STEP_FAST =
    ACC_W'((longint'(FAST_KHZ) * FULL + CLK_KHZ / 2) / CLK_KHZ);
  localparam logic [ACC_W-1:0] STEP_SLOW =
    ACC_W'((longint'(SLOW_KHZ) * FULL + CLK_KHZ / 2) / CLK_KHZ);

  typedef enum logic [2:0] {
    AB_OFF, AB_FAST_BURST, AB_SLOW_BURST, AB_SLOW_RUN, AB_FAST_RUN
  } ab_kind_e;

  function automatic ab_kind_e decode(input logic [2:0] c);
    case (c[1:0])
      2'b00:   decode = AB_OFF;
      2'b10:   decode = AB_FAST_BURST;
      2'b01:   decode = AB_SLOW_BURST;
      default: decode = c[2] ? AB_SLOW_RUN : AB_FAST_RUN;
    endcase
  endfunction

  ab_kind_e         kind_q, kind_d;
  logic [ACC_W-1:0] acc, step;
  logic             chg, is_burst, gate;

  assign kind_d   = decode(mode);
  assign chg      = kind_d != kind_q;
  assign is_burst = (kind_q == AB_FAST_BURST) || (kind_q == AB_SLOW_BURST);
  assign gate     = (kind_q != AB_OFF) && (!is_burst || burst_win);
  assign mode_ok  = kind_q != AB_OFF;

  always_comb begin
    case (kind_q)
      AB_FAST_BURST, AB_FAST_RUN: step = STEP_FAST;
      AB_SLOW_BURST, AB_SLOW_RUN: step = STEP_SLOW;
      default:                    step = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q   <= AB_OFF;
      acc      <= '0;
      ab_pulse <= 1'b0;
    end else if (chg) begin
      kind_q   <= kind_d;
      acc      <= '0;
      ab_pulse <= 1'b0;
    end else begin
      acc      <= acc + step;
      ab_pulse <= gate && !acc[ACC_W-1];
    end
  end

  p_off_silent_r1: assert property (@(posedge clk) disable iff (rst)
    (kind_q == AB_OFF) |=> !ab_pulse);

  p_fast_step_r6: assert property (@(posedge clk) disable iff (rst)
    (!chg && kind_q == AB_FAST_RUN) |=> acc == ACC_W'($past(acc) + STEP_FAST));

  p_slow_step_r6: assert property (@(posedge clk) disable iff (rst)
    (!chg && kind_q == AB_SLOW_RUN) |=> acc == ACC_W'($past(acc) + STEP_SLOW));

  p_window_gate_r7: assert property (@(posedge clk) disable iff (rst)
    (is_burst && !burst_win) |=> !ab_pulse);

  p_restart_r8: assert property (@(posedge clk) disable iff (rst)
    chg |=> (!ab_pulse && acc == '0));

  p_reset_r9: assert property (@(posedge clk)
    rst |=> (!ab_pulse && !mode_ok && acc == '0));

endmodule

// File: tb/sim_ab_pulse_gen.sv
module sim_ab_pulse_gen;
  logic clk = 1'b0, rst = 1'b1, burst_win = 1'b0;
  logic [2:0] mode = 3'b000;
  logic ab_pulse, mode_ok;

  ab_pulse_gen u0 (.clk(clk), .rst(rst), .mode(mode), .burst_win(burst_win),
                   .ab_pulse(ab_pulse), .mode_ok(mode_ok));

  always #2.5 clk = ~clk;

  int tests = 0, fails = 0;
  int cur = 0, k = 0;
  logic e_pulse = 1'b0, e_ok = 1'b0;

  // behaviour codes: 0 off, 1 fast burst, 2 slow burst, 3 slow run, 4 fast run
  function automatic int kind_of(input logic [2:0] c);
    if (c[1:0] == 2'b00) return 0;
    if (c[1:0] == 2'b10) return 1;
    if (c[1:0] == 2'b01) return 2;
    return c[2] ? 3 : 4;
  endfunction

  function automatic string tag_of(input int kd);
    case (kd)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      default: return "R5";
    endcase
  endfunction

  localparam int NV = 13;
  // {mode, win, length}
  localparam logic [11:0] VEC [NV] = '{
    {3'b010, 1'b1, 8'd30}, {3'b110, 1'b1, 8'd20}, {3'b110, 1'b0, 8'd10},
    {3'b001, 1'b1, 8'd30}, {3'b101, 1'b0, 8'd10}, {3'b111, 1'b0, 8'd40},
    {3'b011, 1'b0, 8'd30}, {3'b011, 1'b1, 8'd10}, {3'b000, 1'b1, 8'd10},
    {3'b100, 1'b1, 8'd10}, {3'b010, 1'b1, 8'd15}, {3'b001, 1'b1, 8'd15},
    {3'b101, 1'b1, 8'd20}
  };

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b (k=%0d)", tag, what, act, exp, k);
    end
  endtask

  // expected values from R1..R10, updated after each rising edge
  task automatic model_edge();
    int kd, st;
    kd = kind_of(mode);
    if (rst) begin
      cur = 0; k = 0; e_pulse = 1'b0;
    end else if (kd != cur) begin
      cur = kd; k = 0; e_pulse = 1'b0;      // R8 restart
    end else begin
      k++;
      st = (cur == 1 || cur == 4) ? 9800 : 4900;   // R6
      e_pulse = (cur != 0) && ((cur >= 3) || burst_win) &&  // R7
                ((((k - 1) * st) & 32'hFFFF) < 32768);
    end
    e_ok = (cur != 0);   // R10
  endtask

  task automatic tick_check();
    @(posedge clk); #1;
    model_edge();
    check(tag_of(cur), ab_pulse, e_pulse, "pulse");
    check("R10", mode_ok, e_ok, "mode_ok");
  endtask

  task automatic count_rises(input logic [2:0] m, input int exp_n, input string tag);
    int n;
    logic prev;
    n = 0; prev = 1'b0;
    @(negedge clk); mode = 3'b000; burst_win = 1'b0;
    @(posedge clk); #1; model_edge();
    @(negedge clk); mode = m;
    @(posedge clk); #1; model_edge();   // change edge
    prev = ab_pulse;
    for (int i = 0; i < 134; i++) begin
      @(posedge clk); #1; model_edge();
      if (ab_pulse && !prev) n++;
      prev = ab_pulse;
    end
    tests++;
    if (n != exp_n) begin
      fails++;
      $display("FAIL %s rising edges: actual %0d expected %0d", tag, n, exp_n);
    end
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    model_edge();
    check("R9", ab_pulse, 1'b0, "reset pulse");
    check("R9", mode_ok, 1'b0, "reset mode_ok");
    @(negedge clk); rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      mode = VEC[v][11:9];
      burst_win = VEC[v][8];
      for (int i = 0; i < int'(VEC[v][7:0]); i++) tick_check();
    end

    // R5 and R4: edge counts over 134 cycles
    count_rises(3'b011, 20, "R5");
    count_rises(3'b111, 10, "R4");

    // R8: change while pulse is high forces low on the change edge
    @(negedge clk); mode = 3'b011; burst_win = 1'b1;
    for (int i = 0; i < 2; i++) tick_check();
    check("R8", ab_pulse, 1'b1, "high before change");
    @(negedge clk); mode = 3'b111;
    tick_check();
    check("R8", ab_pulse, 1'b0, "low at change edge");
    tick_check();
    check("R8", ab_pulse, 1'b1, "full pulse resumes");

    // R9: reset mid-train
    @(negedge clk); mode = 3'b011; rst = 1'b1;
    tick_check();
    check("R9", ab_pulse, 1'b0, "pulse under reset");
    check("R9", mode_ok, 1'b0, "mode_ok under reset");
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 12; i++) tick_check();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule